// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt causes of a 16550-style serial port, ranks them by a fixed priority and presents the winner as an identification byte, together with one level-sensitive interrupt line. It takes five causes: receiver line error, receive data available, character timeout, transmit holding empty and modem status change. Each cause has its own event that raises it and its own bus access that clears it. The register decode, the FIFOs and the serial engines sit outside. They supply the FIFO fill level, the line-error flag, the modem change bits, the transmit-empty flag and single-cycle strobes for each relevant register access.

The character timeout counter is part of this block. It counts 16x baud ticks while the receive FIFO holds data and no character has been pushed or popped. The limit is four character times, and a character time is derived from the frame format currently programmed. The enable bits mask what is reported but never stop a cause from being recorded, so enabling a cause late still reports an event that has already happened.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is C1h and the interrupt output is low.
- R2: Bits 7..6 of the identification byte are always 1 and bits 5..4 are always 0. Bit 0 is 0 exactly when an enabled cause is pending, and bits 3..1 are 000 when bit 0 is 1.
- R3: Bits 3..1 report the highest-ranked enabled pending cause. The codes, from highest rank to lowest, are: line error 011 (byte C6h), data available 010 (C4h), timeout 110 (CCh), transmit holding empty 001 (C2h), modem status 000 (C0h).
- R4: The interrupt output is high exactly when an enabled cause is pending. Enable bit 0 gates data available and timeout, bit 1 gates transmit empty, bit 2 gates line error and bit 3 gates modem status. A cause whose enable bit is 0 is still recorded, and it is reported once the bit is set.
- R5: Data available is pending in the cycle after a clock edge at which the FIFO count is at or above the trigger level. It is not pending in the cycle after an edge at which the count is below it. Trigger select 00/01/10/11 means 1/4/8/14 characters.
- R6: The timeout is pending when the FIFO count is non-zero and the tick counter has reached 4 character times. The counter restarts from zero at any edge where the count is zero or a push or buffer read occurs. One character time is 16 ticks for each of the start bit, the data bits (5 + word-length select) and the parity bit if enabled, plus 16 ticks of stop, or 32 when the two-stop bit is set, or 24 when two-stop is set with 5 data bits.
- R7: Transmit empty becomes pending when the empty flag goes from 0 to 1, or when enable bit 1 goes from 0 to 1 while the flag is 1. It is cleared by a holding-register write, or by an identification read made while the byte reports code 001.
- R8: An identification read made while a higher-ranked cause is reported leaves a pending transmit-empty cause in place.
- R9: The line-error cause becomes pending when the error flag goes from 0 to 1, and it is cleared by a line-status read.
- R10: The modem cause becomes pending when any of the four change bits goes from 0 to 1, and it is cleared by a modem-status read. In the same cycle a new raising event overrides the clearing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Cause enable bits |
| lsr_err_i | input | 1 | Receiver line error flag (level) |
| rx_count_i | input | CNT_W | Receive FIFO fill level |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_push_i | input | 1 | A character entered the receive FIFO |
| baud_tick_i | input | 1 | 16x baud rate tick |
| wlen_i | input | 2 | Word length select (data bits = 5 + value) |
| par_en_i | input | 1 | Parity bit present in frame |
| stop2_i | input | 1 | Long stop period selected |
| tx_empty_i | input | 1 | Transmit FIFO empty flag |
| msr_delta_i | input | 4 | Modem line change bits |
| lsr_rd_i | input | 1 | Line status read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| iir_rd_i | input | 1 | Identification read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| thr_wr_i | input | 1 | Transmit holding write strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 5-bit FIFO count, 16 ticks per bit and a 4-character timeout. With these values the highest trigger level of 14 can be reached, and the timeout limits run from 448 to 768 ticks. Driving a tick on every cycle puts the shortest frame, the 1.5-stop frame and the longest frame within a few hundred cycles each. A behavioural reference model is compared against the block on every cycle of the directed sequences and of a long random phase, so that coincident raises, clears and priority changes are also exercised.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

    typedef enum logic [2:0] {
        SRC_LS   = 3'b011,
        SRC_RDA  = 3'b010,
        SRC_TO   = 3'b110,
        SRC_THRE = 3'b001,
        SRC_MS   = 3'b000
    } irq_code_e;

    localparam int NSRC = 5;

    // index 0 is the highest rank
    localparam irq_code_e RANK_CODE [NSRC] = '{SRC_LS, SRC_RDA, SRC_TO, SRC_THRE, SRC_MS};

    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    // frame length counted in half bit periods
    function automatic int frame_halfbits(input logic [1:0] wlen, input logic par, input logic stop2);
        int stop_half;
        if (!stop2)            stop_half = 2;
        else if (wlen == 2'd0) stop_half = 3;
        else                   stop_half = 4;
        return 2 * (6 + int'(wlen) + int'(par)) + stop_half;
    endfunction

endpackage

// File: rtl/irq_char_timer.sv
`timescale 1ns/1ps
module irq_char_timer
    import uart_irq_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int TO_CHARS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [1:0] wlen_i,
    input  logic       par_en_i,
    input  logic       stop2_i,
    input  logic       rx_nonempty_i,
    input  logic       activity_i,
    output logic       expired_o
);
    localparam int HALF_SPAN = TO_CHARS * OVERSAMPLE / 2;
    localparam int LIM_MAX   = HALF_SPAN * 24;
    localparam int CW        = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t          t_q, t_d;
    logic [CW-1:0] limit;

    always_comb begin
        limit = CW'(HALF_SPAN * frame_halfbits(wlen_i, par_en_i, stop2_i));
        t_d   = t_q;
        if (!rx_nonempty_i || activity_i)
            t_d.cnt = '0;
        else if (tick_i && (t_q.cnt < limit))
            t_d.cnt = t_q.cnt + 1'b1;
        expired_o = rx_nonempty_i && (t_q.cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/irq_rank.sv
`timescale 1ns/1ps
module irq_rank
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    output irq_code_e       code_o,
    output logic            any_o
);
    always_comb begin
        code_o = SRC_MS;
        any_o  = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                code_o = RANK_CODE[i];
                any_o  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int OVERSAMPLE = 16,
    parameter int TO_CHARS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier_i,
    input  logic             lsr_err_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             rx_push_i,
    input  logic             baud_tick_i,
    input  logic [1:0]       wlen_i,
    input  logic             par_en_i,
    input  logic             stop2_i,
    input  logic             tx_empty_i,
    input  logic [3:0]       msr_delta_i,
    input  logic             lsr_rd_i,
    input  logic             rbr_rd_i,
    input  logic             iir_rd_i,
    input  logic             msr_rd_i,
    input  logic             thr_wr_i,
    output logic [7:0]       iir_o,
    output logic             irq_o
);
    typedef struct packed {
        logic       ls_pend;
        logic       ms_pend;
        logic       thre_pend;
        logic       rda;
        logic       err_prev;
        logic [3:0] delta_prev;
        logic       txe_prev;
        logic       thre_en_prev;
    } ident_t;

    localparam ident_t RESET_ST = '{ls_pend: 1'b0, ms_pend: 1'b0, thre_pend: 1'b0,
                                    rda: 1'b0, err_prev: 1'b0, delta_prev: 4'h0,
                                    txe_prev: 1'b1, thre_en_prev: 1'b0};

    ident_t          s_q, s_d;
    logic            to_hit;
    logic [NSRC-1:0] req;
    irq_code_e       code;
    logic            any;
    logic            thre_raise;
    logic            thre_ack;

    irq_char_timer #(
        .OVERSAMPLE (OVERSAMPLE),
        .TO_CHARS   (TO_CHARS)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (baud_tick_i),
        .wlen_i        (wlen_i),
        .par_en_i      (par_en_i),
        .stop2_i       (stop2_i),
        .rx_nonempty_i (rx_count_i != '0),
        .activity_i    (rx_push_i | rbr_rd_i),
        .expired_o     (to_hit)
    );

    // ranking order follows RANK_CODE
    assign req = {s_q.ms_pend   & ier_i[3],
                  s_q.thre_pend & ier_i[1],
                  to_hit        & ier_i[0],
                  s_q.rda       & ier_i[0],
                  s_q.ls_pend   & ier_i[2]};

    irq_rank u_rank (
        .req_i  (req),
        .code_o (code),
        .any_o  (any)
    );

    always_comb begin
        s_d = s_q;

        s_d.rda = int'(rx_count_i) >= trig_level(trig_sel_i);

        if (lsr_err_i && !s_q.err_prev) s_d.ls_pend = 1'b1;
        else if (lsr_rd_i)              s_d.ls_pend = 1'b0;

        if ((msr_delta_i & ~s_q.delta_prev) != 4'h0) s_d.ms_pend = 1'b1;
        else if (msr_rd_i)                           s_d.ms_pend = 1'b0;

        thre_raise = tx_empty_i && (!s_q.txe_prev || (ier_i[1] && !s_q.thre_en_prev));
        thre_ack   = thr_wr_i || (iir_rd_i && any && (code == SRC_THRE));
        if (thre_raise)    s_d.thre_pend = 1'b1;
        else if (thre_ack) s_d.thre_pend = 1'b0;

        s_d.err_prev     = lsr_err_i;
        s_d.delta_prev   = msr_delta_i;
        s_d.txe_prev     = tx_empty_i;
        s_d.thre_en_prev = ier_i[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_ST;
        else        s_q <= s_d;
    end

    assign iir_o = {2'b11, 2'b00, any ? code : SRC_MS, ~any};
    assign irq_o = any;
endmodule

// File: rtl/uart_irq_ident_chk.sv
`timescale 1ns/1ps
module uart_irq_ident_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       ier_i,
    input logic             lsr_err_i,
    input logic             lsr_rd_i,
    input logic [3:0]       msr_delta_i,
    input logic             msr_rd_i,
    input logic             thr_wr_i,
    input logic             tx_empty_i,
    input logic [CNT_W-1:0] rx_count_i,
    input logic [7:0]       iir_o,
    input logic             irq_o
);
    // R9: line-status read with the flag low removes the line-error report
    p_ls_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd_i && !lsr_err_i) |=> (iir_o[3:1] != 3'b011));

    // R9 / R3: a fresh error with its enable set is reported at top rank
    p_ls_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lsr_err_i) |=> (!ier_i[2] || iir_o[3:0] == 4'b0110));

    // R10: modem read with no new change bits removes the modem report
    p_ms_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && msr_delta_i == 4'h0) |=> !(iir_o[3:0] == 4'b0000));

    // R7: a holding write while not empty removes the transmit-empty report
    p_thre_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !tx_empty_i) |=> (iir_o[3:0] != 4'b0010));

    // R5: an empty FIFO leaves no data-available report behind
    p_rda_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count_i == '0) |=> (iir_o[3:1] != 3'b010));

    // R6: no timeout report while the FIFO is empty
    p_no_to_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count_i == '0) |-> (iir_o[3:1] != 3'b110));

    // R2 / R4: fixed bits and consistency between pending flag and line
    p_frame_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_o[7:4] == 4'hC) && (irq_o == !iir_o[0]) && (!iir_o[0] || iir_o[3:1] == 3'b000));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ier_i       (ier_i),
    .lsr_err_i   (lsr_err_i),
    .lsr_rd_i    (lsr_rd_i),
    .msr_delta_i (msr_delta_i),
    .msr_rd_i    (msr_rd_i),
    .thr_wr_i    (thr_wr_i),
    .tx_empty_i  (tx_empty_i),
    .rx_count_i  (rx_count_i),
    .iir_o       (iir_o),
    .irq_o       (irq_o)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       ier_i = 4'h0;
    logic             lsr_err_i = 1'b0;
    logic [CNT_W-1:0] rx_count_i = '0;
    logic [1:0]       trig_sel_i = 2'd0;
    logic             rx_push_i = 1'b0;
    logic             baud_tick_i = 1'b0;
    logic [1:0]       wlen_i = 2'd0;
    logic             par_en_i = 1'b0;
    logic             stop2_i = 1'b0;
    logic             tx_empty_i = 1'b1;
    logic [3:0]       msr_delta_i = 4'h0;
    logic             lsr_rd_i = 1'b0;
    logic             rbr_rd_i = 1'b0;
    logic             iir_rd_i = 1'b0;
    logic             msr_rd_i = 1'b0;
    logic             thr_wr_i = 1'b0;
    logic [7:0]       iir_o;
    logic             irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) dut (
        .clk, .rst_n, .ier_i, .lsr_err_i, .rx_count_i, .trig_sel_i, .rx_push_i,
        .baud_tick_i, .wlen_i, .par_en_i, .stop2_i, .tx_empty_i, .msr_delta_i,
        .lsr_rd_i, .rbr_rd_i, .iir_rd_i, .msr_rd_i, .thr_wr_i, .iir_o, .irq_o
    );

    // ---------------- reference model ----------------
    bit m_ls, m_ms, m_thre, m_rda, m_err_prev, m_txe_prev, m_en1_prev;
    logic [3:0] m_dprev;
    int m_cnt;

    function automatic int char_ticks();
        int stop_t;
        stop_t = !stop2_i ? 16 : (wlen_i == 2'd0 ? 24 : 32);
        return 16 * (1 + 5 + int'(wlen_i) + int'(par_en_i)) + stop_t;
    endfunction

    function automatic int rx_level();
        int lv [4] = '{1, 4, 8, 14};
        return lv[trig_sel_i];
    endfunction

    function automatic logic [7:0] model_iir();
        if (m_ls && ier_i[2])                                          return 8'hC6;
        if (m_rda && ier_i[0])                                         return 8'hC4;
        if (ier_i[0] && rx_count_i != 0 && m_cnt >= 4 * char_ticks())  return 8'hCC;
        if (m_thre && ier_i[1])                                        return 8'hC2;
        if (m_ms && ier_i[3])                                          return 8'hC0;
        return 8'hC1;
    endfunction

    function automatic string tag_of(input logic [7:0] v);
        case (v)
            8'hC6:   return "R9";
            8'hC4:   return "R5";
            8'hCC:   return "R6";
            8'hC2:   return "R7";
            8'hC0:   return "R10";
            default: return "R4";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ls = 0; m_ms = 0; m_thre = 0; m_rda = 0; m_err_prev = 0;
            m_txe_prev = 1; m_en1_prev = 0; m_dprev = 4'h0; m_cnt = 0;
        end else begin
            logic [7:0] now;
            now = model_iir();
            if (tx_empty_i && (!m_txe_prev || (ier_i[1] && !m_en1_prev))) m_thre = 1;
            else if (thr_wr_i || (iir_rd_i && now == 8'hC2))              m_thre = 0;
            if (lsr_err_i && !m_err_prev) m_ls = 1;
            else if (lsr_rd_i)            m_ls = 0;
            if ((msr_delta_i & ~m_dprev) != 4'h0) m_ms = 1;
            else if (msr_rd_i)                    m_ms = 0;
            m_rda = int'(rx_count_i) >= rx_level();
            if (rx_count_i == 0 || rx_push_i || rbr_rd_i) m_cnt = 0;
            else if (baud_tick_i && m_cnt < 4 * char_ticks()) m_cnt++;
            m_err_prev = lsr_err_i; m_dprev = msr_delta_i;
            m_txe_prev = tx_empty_i; m_en1_prev = ier_i[1];
        end
    end

    // per-cycle comparison, half a period after the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e;
            e = model_iir();
            n_chk++;
            if (iir_o !== e || irq_o !== !e[0]) begin
                n_fail++;
                $display("FAIL %s model compare: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                         tag_of(e), iir_o, irq_o, e, !e[0]);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [7:0] exp);
        n_chk++;
        if (iir_o !== exp || irq_o !== !exp[0]) begin
            n_fail++;
            $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     tag, iir_o, irq_o, exp, !exp[0]);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        chk("R1", 8'hC1);
        rst_n = 1'b1;
        step();
        chk("R1", 8'hC1);

        // R5: trigger 4 then 14
        ier_i = 4'b0001; trig_sel_i = 2'd1; rx_count_i = 5'd3;
        step(); chk("R5", 8'hC1);
        rx_count_i = 5'd4;  step(); chk("R5", 8'hC4);
        rx_count_i = 5'd3;  step(); chk("R5", 8'hC1);
        trig_sel_i = 2'd3; rx_count_i = 5'd13; step(); chk("R5", 8'hC1);
        rx_count_i = 5'd14; step(); chk("R5", 8'hC4);
        rx_count_i = 5'd0;  step(); chk("R5", 8'hC1);

        // R6: 5 data bits, no parity, one stop: 448 ticks
        rx_count_i = 5'd1; rx_push_i = 1'b1; step();
        rx_push_i = 1'b0; baud_tick_i = 1'b1;
        repeat (447) step();
        chk("R6", 8'hC1);
        step(); chk("R6", 8'hCC);
        rbr_rd_i = 1'b1; rx_count_i = 5'd0; step(); chk("R6", 8'hC1);
        rbr_rd_i = 1'b0;

        // R6: 1.5 stop with 5 data bits: 480 ticks, push restarts
        stop2_i = 1'b1; rx_count_i = 5'd1; rx_push_i = 1'b1; step();
        rx_push_i = 1'b0;
        repeat (479) step();
        chk("R6", 8'hC1);
        step(); chk("R6", 8'hCC);
        rx_push_i = 1'b1; rx_count_i = 5'd2; step(); chk("R6", 8'hC1);
        rx_push_i = 1'b0; baud_tick_i = 1'b0; rx_count_i = 5'd0; stop2_i = 1'b0;
        step();

        // R7: enable rising while empty, identification ack, write, empty rising
        ier_i = 4'b0010; step(); chk("R7", 8'hC2);
        iir_rd_i = 1'b1; step(); chk("R7", 8'hC1);
        iir_rd_i = 1'b0; thr_wr_i = 1'b1; tx_empty_i = 1'b0; step(); chk("R7", 8'hC1);
        thr_wr_i = 1'b0; step();
        tx_empty_i = 1'b1; step(); chk("R7", 8'hC2);
        thr_wr_i = 1'b1; step(); chk("R7", 8'hC1);
        thr_wr_i = 1'b0;

        // R8: identification read under a higher cause keeps transmit empty
        ier_i = 4'b0110; tx_empty_i = 1'b0; step();
        tx_empty_i = 1'b1; step(); chk("R8", 8'hC2);
        lsr_err_i = 1'b1; step(); chk("R9", 8'hC6);
        iir_rd_i = 1'b1; step(); chk("R8", 8'hC6);
        iir_rd_i = 1'b0; lsr_rd_i = 1'b1; lsr_err_i = 1'b0; step(); chk("R8", 8'hC2);
        lsr_rd_i = 1'b0; iir_rd_i = 1'b1; step(); chk("R7", 8'hC1);
        iir_rd_i = 1'b0;

        // R4 / R10: disabled modem cause latched, reported once enabled
        ier_i = 4'b0000; msr_delta_i = 4'b0100; step(); chk("R4", 8'hC1);
        ier_i = 4'b1000; step(); chk("R4", 8'hC0);
        msr_rd_i = 1'b1; msr_delta_i = 4'b0101; step(); chk("R10", 8'hC0);
        msr_delta_i = 4'b0000; step(); chk("R10", 8'hC1);
        msr_rd_i = 1'b0;

        // R3: full ranking with 8 data bits, parity, two stop: 768 ticks
        ier_i = 4'b1111; trig_sel_i = 2'd0; wlen_i = 2'd3; par_en_i = 1'b1; stop2_i = 1'b1;
        tx_empty_i = 1'b0; step();
        tx_empty_i = 1'b1; msr_delta_i = 4'b0010; step(); chk("R3", 8'hC2);
        rx_count_i = 5'd1; step(); chk("R3", 8'hC4);
        lsr_err_i = 1'b1; step(); chk("R3", 8'hC6);
        lsr_rd_i = 1'b1; lsr_err_i = 1'b0; step(); chk("R9", 8'hC4);
        lsr_rd_i = 1'b0; trig_sel_i = 2'd3; step(); chk("R3", 8'hC2);
        baud_tick_i = 1'b1;
        repeat (767) step();
        chk("R6", 8'hC2);
        step(); chk("R3", 8'hCC);
        baud_tick_i = 1'b0; rbr_rd_i = 1'b1; rx_count_i = 5'd0; step(); chk("R3", 8'hC2);
        rbr_rd_i = 1'b0; thr_wr_i = 1'b1; step(); chk("R3", 8'hC0);
        thr_wr_i = 1'b0; msr_rd_i = 1'b1; msr_delta_i = 4'h0; step(); chk("R10", 8'hC1);
        msr_rd_i = 1'b0; step(); chk("R2", 8'hC1);

        // random phase, compared against the model every cycle
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 15) == 0) ier_i = 4'($urandom);
            if ($urandom_range(0, 7) == 0)  lsr_err_i = ~lsr_err_i;
            if ($urandom_range(0, 15) == 0) rx_count_i = 5'($urandom_range(0, 16));
            if ($urandom_range(0, 63) == 0) trig_sel_i = 2'($urandom);
            if ($urandom_range(0, 127) == 0) begin
                wlen_i = 2'($urandom); par_en_i = 1'($urandom); stop2_i = 1'($urandom);
            end
            if ($urandom_range(0, 7) == 0)  tx_empty_i = ~tx_empty_i;
            if ($urandom_range(0, 7) == 0)  msr_delta_i = 4'($urandom);
            baud_tick_i = ($urandom_range(0, 3) != 0);
            rx_push_i   = ($urandom_range(0, 31) == 0);
            rbr_rd_i    = ($urandom_range(0, 31) == 0);
            lsr_rd_i    = ($urandom_range(0, 7) == 0);
            iir_rd_i    = ($urandom_range(0, 7) == 0);
            msr_rd_i    = ($urandom_range(0, 7) == 0);
            thr_wr_i    = ($urandom_range(0, 15) == 0);
            step();
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule